// File: doc/BRIEF.md
# DAC Code Commit and Write-Status Controller

This block sits behind a serial slave front end and owns the code register of a 12-bit digital-to-analog converter. The front end hands it every data byte it receives, as an address and value pulse, and marks the end of each write transaction with a one-cycle pulse when chip select returns high. Bytes are staged while the transaction is in progress. When the transaction ends, the block checks it and commits it as a whole, or discards it as a whole.

A volatile mode bit chooses where a DAC code write goes. With the bit clear, the code lands in the live register that drives the converter. With the bit set, it lands in a persistent start-up copy instead, and a timed busy cycle begins. That cycle stands in for the programming time of real non-volatile storage, and a write-in-progress flag reports it. Readback of the two code bytes follows the mode bit in the same way. Reset reloads the live code from the start-up copy, and the copy itself survives reset.

Byte order within a transaction is free. The front end never raises a byte pulse in the same cycle as the end pulse.

Top module: `dac_commit_ctrl`

## Requirements
- R1: After reset the mode bit is 0, `wip` is 0, and `dac_code` equals the start-up copy, which is `NV_INIT` until the copy is first programmed.
- R2: At the end of a transaction, a byte 80h written to address 3Fh sets the mode bit and a byte 00h clears it. Any other value written there leaves the bit unchanged. Reading 3Fh returns the mode bit in bit 7 with bits 6:0 zero.
- R3: Address 38h carries code bits 7:0 and bits 3:0 of address 39h carry code bits 11:8. With the mode bit 0, a valid code write updates `dac_code` on the clock edge that samples `txn_end`.
- R4: With the mode bit 1, a valid code write updates the start-up copy, leaves `dac_code` unchanged, and starts a busy cycle.
- R5: Reading 38h/39h returns the start-up copy when the mode bit is 1 and the live code when it is 0.
- R6: A code write is valid only if the transaction holds exactly two bytes, one to 38h and one to 39h. Any other code write is discarded whole.
- R7: A write to the configuration byte at 3Ch commits only when it is the single byte of its transaction. Reading 3Ch returns the stored value.
- R8: `wip` rises in the cycle after the `txn_end` that starts a busy cycle and stays 1 for exactly `BUSY_CYCLES` cycles. Volatile writes never raise it.
- R9: While `wip` is 1, byte pulses and `txn_end` have no effect on any stored value.
- R10: Reset leaves the start-up copy intact and loads it into `dac_code`.
- R11: Bits 7:4 of 39h read as 0. Unmapped addresses read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A byte was received this cycle |
| wr_addr | input | 6 | Address of the received byte |
| wr_data | input | 8 | Value of the received byte |
| txn_end | input | 1 | One-cycle pulse when the transaction ends |
| rd_addr | input | 6 | Readback address |
| rd_data | output | 8 | Readback value, combinational from `rd_addr` |
| dac_code | output | 12 | Live code driving the converter |
| wip | output | 1 | Busy cycle in progress |

## Verification
The bench builds the block with `BUSY_CYCLES` set to 20 instead of a count on the order of a 10 ms delay. This makes the busy window short enough to measure cycle by cycle and to fill with ignored traffic. `NV_INIT` is set to 800h, so the first readback of the start-up copy gives a value that no earlier write could have produced. With these values, one run can program the copy, reset the block, and confirm that the live code comes back as the last programmed value.

// File: rtl/dac_cc_pkg.sv
package dac_cc_pkg;
    localparam int ADDR_W = 6;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 12;
    localparam int HI_W   = CODE_W - BYTE_W;
    localparam int CNT_W  = 2;

    localparam logic [ADDR_W-1:0] A_CODE_LO = 6'h38;
    localparam logic [ADDR_W-1:0] A_CODE_HI = 6'h39;
    localparam logic [ADDR_W-1:0] A_CFG     = 6'h3C;
    localparam logic [ADDR_W-1:0] A_MODE    = 6'h3F;

    localparam logic [BYTE_W-1:0] MODE_SET_VAL = 8'h80;
    localparam logic [BYTE_W-1:0] MODE_CLR_VAL = 8'h00;

    // staging of one write transaction
    typedef struct packed {
        logic [CNT_W-1:0]  nbytes;   // saturating byte count
        logic              got_lo;
        logic              got_hi;
        logic              got_cfg;
        logic              mode_ok;
        logic              mode_val;
        logic [BYTE_W-1:0] lo;
        logic [HI_W-1:0]   hi;
        logic [BYTE_W-1:0] cfg;
    } stage_t;

    // architectural registers that take reset
    typedef struct packed {
        logic [CODE_W-1:0] live;
        logic              mode;
        logic [BYTE_W-1:0] cfg;
    } core_t;
endpackage

// File: rtl/dac_txn_stager.sv
module dac_txn_stager
    import dac_cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              txn_end,
    input  logic              busy,
    output logic              commit_code,
    output logic              commit_cfg,
    output logic              commit_mode,
    output logic [CODE_W-1:0] code_val,
    output logic [BYTE_W-1:0] cfg_val,
    output logic              mode_val
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    stage_t st_d, st_q;
    logic   accept;
    logic   fire;

    assign accept = wr_valid && !busy && !txn_end;
    assign fire   = txn_end && !busy;

    always_comb begin
        st_d = st_q;
        if (txn_end) begin
            st_d = '0;
        end else if (accept) begin
            if (st_q.nbytes != CNT_MAX)
                st_d.nbytes = st_q.nbytes + 1'b1;
            case (wr_addr)
                A_CODE_LO: begin
                    st_d.got_lo = 1'b1;
                    st_d.lo     = wr_data;
                end
                A_CODE_HI: begin
                    st_d.got_hi = 1'b1;
                    st_d.hi     = wr_data[HI_W-1:0];
                end
                A_CFG: begin
                    st_d.got_cfg = 1'b1;
                    st_d.cfg     = wr_data;
                end
                A_MODE: begin
                    if (wr_data == MODE_SET_VAL) begin
                        st_d.mode_ok  = 1'b1;
                        st_d.mode_val = 1'b1;
                    end else if (wr_data == MODE_CLR_VAL) begin
                        st_d.mode_ok  = 1'b1;
                        st_d.mode_val = 1'b0;
                    end else begin
                        st_d.mode_ok  = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_code = fire && st_q.got_lo && st_q.got_hi && (st_q.nbytes == 2'd2);
    assign commit_cfg  = fire && st_q.got_cfg && (st_q.nbytes == 2'd1);
    assign commit_mode = fire && st_q.mode_ok;
    assign code_val    = {st_q.hi, st_q.lo};
    assign cfg_val     = st_q.cfg;
    assign mode_val    = st_q.mode_val;
endmodule

// File: rtl/dac_busy_timer.sv
module dac_busy_timer #(
    parameter int unsigned BUSY_CYCLES = 500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] left;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start && !t_q.busy) begin
            t_d.busy = 1'b1;
            t_d.left = LOAD;
        end else if (t_q.busy) begin
            if (t_q.left == '0) t_d.busy = 1'b0;
            else                t_d.left = t_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;
endmodule

// File: rtl/dac_readback_mux.sv
module dac_readback_mux
    import dac_cc_pkg::*;
(
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              mode,
    input  logic [CODE_W-1:0] live,
    input  logic [CODE_W-1:0] stored,
    input  logic [BYTE_W-1:0] cfg,
    output logic [BYTE_W-1:0] rd_data
);
    logic [CODE_W-1:0] shown;

    assign shown = mode ? stored : live;

    always_comb begin
        case (rd_addr)
            A_CODE_LO: rd_data = shown[BYTE_W-1:0];
            A_CODE_HI: rd_data = {{(BYTE_W-HI_W){1'b0}}, shown[CODE_W-1:BYTE_W]};
            A_CFG:     rd_data = cfg;
            A_MODE:    rd_data = {mode, {(BYTE_W-1){1'b0}}};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dac_commit_ctrl.sv
module dac_commit_ctrl
    import dac_cc_pkg::*;
#(
    parameter int unsigned       BUSY_CYCLES = 500_000,
    parameter logic [CODE_W-1:0] NV_INIT     = 12'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              txn_end,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CODE_W-1:0] dac_code,
    output logic              wip
);
    logic              commit_code, commit_cfg, commit_mode;
    logic [CODE_W-1:0] code_val;
    logic [BYTE_W-1:0] cfg_val;
    logic              mode_val;
    logic              busy;
    logic              nv_we;
    logic [CODE_W-1:0] nv_q = NV_INIT;  // persistent copy: no reset
    core_t             core_d, core_q;
    logic              mode_q;

    dac_txn_stager u_stager (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .txn_end     (txn_end),
        .busy        (busy),
        .commit_code (commit_code),
        .commit_cfg  (commit_cfg),
        .commit_mode (commit_mode),
        .code_val    (code_val),
        .cfg_val     (cfg_val),
        .mode_val    (mode_val)
    );

    dac_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_we),
        .busy  (busy)
    );

    // code routing uses the mode in force before this transaction
    always_comb begin
        core_d = core_q;
        nv_we  = commit_code && core_q.mode;
        if (commit_code && !core_q.mode) core_d.live = code_val;
        if (commit_cfg)                  core_d.cfg  = cfg_val;
        if (commit_mode)                 core_d.mode = mode_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q.live <= nv_q;
            core_q.mode <= 1'b0;
            core_q.cfg  <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && nv_we) nv_q <= code_val;
    end

    dac_readback_mux u_rdmux (
        .rd_addr (rd_addr),
        .mode    (core_q.mode),
        .live    (core_q.live),
        .stored  (nv_q),
        .cfg     (core_q.cfg),
        .rd_data (rd_data)
    );

    assign mode_q   = core_q.mode;
    assign dac_code = core_q.live;
    assign wip      = busy;
endmodule

// File: rtl/dac_commit_ctrl_chk.sv
module dac_commit_ctrl_chk
    import dac_cc_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 500_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_end,
    input logic              wip,
    input logic              mode,
    input logic [CODE_W-1:0] dac_code,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [BYTE_W-1:0] rd_data
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (!rst_n || !wip) run_len <= 0;
        else                run_len <= run_len + 1;
    end

    // R8
    wip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(txn_end));

    // R4
    wip_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(mode));

    // R8
    wip_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> run_len < BUSY_CYCLES);

    // R8
    wip_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> run_len == BUSY_CYCLES);

    // R3
    code_moves_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $past(txn_end) && !$past(mode));

    // R9
    frozen_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wip) |-> $stable(dac_code) && $stable(mode));

    // R11
    hi_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_CODE_HI) |-> rd_data[7:4] == 4'h0);

    // R2
    mode_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_MODE) |-> rd_data == {mode, 7'b0});
endmodule

bind dac_commit_ctrl dac_commit_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txn_end  (txn_end),
    .wip      (wip),
    .mode     (mode_q),
    .dac_code (dac_code),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/tb_dac_commit_ctrl.sv
module tb_dac_commit_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  BUSY = 20;
    localparam logic [11:0] INIT = 12'h800;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       txn_end = 1'b0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [11:0] dac_code;
    logic       wip;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_commit_ctrl #(.BUSY_CYCLES(BUSY), .NV_INIT(INIT)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .txn_end(txn_end), .rd_addr(rd_addr),
        .rd_data(rd_data), .dac_code(dac_code), .wip(wip)
    );

    // {nbytes[1:0], a0[5:0], d0[7:0], a1[5:0], d1[7:0], expected code[11:0]}
    localparam logic [41:0] VEC [6] = '{
        {2'd2, 6'h38, 8'h34, 6'h39, 8'h12, 12'h234},
        {2'd2, 6'h39, 8'h0F, 6'h38, 8'hFF, 12'hFFF},
        {2'd1, 6'h38, 8'h55, 6'h00, 8'h00, 12'hFFF},
        {2'd2, 6'h38, 8'h00, 6'h3C, 8'h00, 12'hFFF},
        {2'd2, 6'h38, 8'h00, 6'h39, 8'h00, 12'h000},
        {2'd2, 6'h38, 8'hA5, 6'h39, 8'hF3, 12'h3A5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic finish_txn();
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 code", dac_code, INIT);
        check("R1 wip", wip, 0);
        rd(6'h3F, v); check("R1 mode", v, 8'h00);
        rd(6'h39, v); check("R11 hi read", v, 8'h08);
        rd(6'h20, v); check("R11 unmapped", v, 8'h00);

        // R3/R6: volatile code writes from the vector table
        foreach (VEC[i]) begin
            @(negedge clk);
            put(VEC[i][39:34], VEC[i][33:26]);
            if (VEC[i][41:40] == 2'd2) put(VEC[i][25:20], VEC[i][19:12]);
            finish_txn();
            check("R3/R6 code", dac_code, VEC[i][11:0]);
            check("R8 no wip on volatile", wip, 0);
            rd(6'h38, v); check("R5 live lo", v, VEC[i][7:0]);
            rd(6'h39, v); check("R11 live hi", v, {4'h0, VEC[i][11:8]});
        end

        // R6: three bytes discarded
        put(6'h38, 8'h01); put(6'h39, 8'h01); put(6'h38, 8'h02); finish_txn();
        check("R6 three bytes", dac_code, 12'h3A5);

        // R7: configuration byte
        put(6'h3C, 8'h5A); finish_txn();
        rd(6'h3C, v); check("R7 single cfg", v, 8'h5A);
        put(6'h3C, 8'h11); put(6'h3C, 8'h22); finish_txn();
        rd(6'h3C, v); check("R7 multi cfg discarded", v, 8'h5A);

        // R2: mode bit
        put(6'h3F, 8'h01); finish_txn();
        rd(6'h3F, v); check("R2 bad value ignored", v, 8'h00);
        put(6'h3F, 8'h80); finish_txn();
        rd(6'h3F, v); check("R2 set", v, 8'h80);
        rd(6'h38, v); check("R5 stored lo", v, 8'h00);
        rd(6'h39, v); check("R5 stored hi", v, 8'h08);

        // R4/R8: persistent write and busy length
        put(6'h38, 8'h11); put(6'h39, 8'h07);
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
        check("R8 wip rises", wip, 1);
        check("R4 code held", dac_code, 12'h3A5);
        n = 0;
        while (wip && n < 1000) begin n++; @(negedge clk); end
        check("R8 busy length", n, BUSY);
        rd(6'h38, v); check("R4/R5 stored lo", v, 8'h11);
        rd(6'h39, v); check("R4/R5 stored hi", v, 8'h07);

        // R9: traffic during busy is ignored
        put(6'h38, 8'h22); put(6'h39, 8'h03); finish_txn();
        check("R9 wip up", wip, 1);
        put(6'h3F, 8'h00); finish_txn();
        put(6'h38, 8'h99); put(6'h39, 8'h09); finish_txn();
        put(6'h3C, 8'hEE); finish_txn();
        n = 0;
        while (wip && n < 1000) begin n++; @(negedge clk); end
        rd(6'h3F, v); check("R9 mode kept", v, 8'h80);
        rd(6'h38, v); check("R9 stored lo", v, 8'h22);
        rd(6'h39, v); check("R9 stored hi", v, 8'h03);
        rd(6'h3C, v); check("R9 cfg kept", v, 8'h5A);
        check("R9 code kept", dac_code, 12'h3A5);

        // R2/R5: back to live view
        put(6'h3F, 8'h00); finish_txn();
        rd(6'h3F, v); check("R2 clear", v, 8'h00);
        rd(6'h38, v); check("R5 live lo", v, 8'hA5);

        // R10: reset reloads from the stored copy
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reload", dac_code, 12'h322);
        check("R1 wip after reset", wip, 0);
        rd(6'h3F, v); check("R1 mode after reset", v, 8'h00);

        summary();
    end
endmodule